// File: doc/BRIEF.md
# Gated Serial Output Clock Generator

This block produces the serial bit clock that feeds external sigma-delta modulators. It divides a selected source clock by a programmable integer ratio. Each source clock reaches the block as a single-cycle enable pulse in the fabric clock domain. A global interface enable gates the whole generator. A divide setting of zero keeps the generator idle. The locked divide setting is also presented on a separate output, so that a neighbouring clock-absence monitor can use it as its threshold.

The divide value and the source choice are copied into locked registers only while the interface is disabled. Writes made while the interface runs are held back until the next disabled cycle. When the interface is enabled, the divider counter starts from zero. Every period therefore begins cleanly with a rising edge of the output clock.

Top module: `sdm_clkout_gen`

## Requirements
- R1: While `rst` is high, at the next clock edge `ser_clk` goes to 0 and `absence_thr` goes to 0.
- R2: With the interface enabled and a locked divide value D from 1 to 255, `ser_clk` repeats every D+1 pulses of the selected source enable, so ratios run from 2 to 256.
- R3: In each output period of N = D+1 source pulses, `ser_clk` is high for ceil(N/2) pulses and low for floor(N/2) pulses. For odd N the high phase is one source pulse longer than the low phase.
- R4: A locked divide value of 0 holds `ser_clk` low for as long as the interface is enabled.
- R5: A clock edge that samples `glb_en` low drives `ser_clk` low, so the output is low one cycle after the enable clears. The divider position returns to zero at the same edge.
- R6: While `glb_en` is high, changes on `div_cfg` and `src_sel` have no effect on `absence_thr` or on `ser_clk`. The values present at the last edge that sampled `glb_en` low stay in force.
- R7: `src_sel` = 0 picks `src_ce[0]` (the system clock enable) and `src_sel` = 1 picks `src_ce[1]` (the audio clock enable). Pulses on the source that is not selected do not move the output.
- R8: `absence_thr` equals the locked divide value. While `glb_en` is low it follows `div_cfg` with one cycle of delay.
- R9: After `glb_en` rises, the first selected source pulse drives `ser_clk` high. That pulse starts a full-length period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; every register is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global interface enable |
| src_sel | input | SEL_W (1) | Source choice: 0 system, 1 audio |
| div_cfg | input | DIV_W (8) | Divide setting D; the ratio is D+1 and 0 means off |
| src_ce | input | NSRC (2) | Per-source single-cycle clock enables |
| ser_clk | output | 1 | Registered serial output clock |
| absence_thr | output | DIV_W (8) | Locked divide value, used as the clock-absence threshold |

## Verification
The divider is run at even and odd ratios, including the extreme ratios of 2 and 256. These runs separate the period length (R2) from the high/low split (R3). Source pulses arrive every cycle, every third cycle and in a pseudo-random pattern, with the two sources pulsing independently. This shows that only the selected enable advances the counter (R7), and that gaps in the pulses stretch the output rather than corrupting its phase. Writes to the settings made mid-run, a disable taken while the output is high, and a divide value of zero show the lock (R6), the one-cycle shutdown (R5) and the idle state (R4).

// File: rtl/ocg_pkg.sv
package ocg_pkg;
  localparam int OCG_DIV_W_DEF = 8;
  localparam int OCG_NSRC_DEF  = 2;

  function automatic int sel_width(input int nsrc);
    return (nsrc > 1) ? $clog2(nsrc) : 1;
  endfunction
endpackage

// File: rtl/ocg_cfg_lock.sv
module ocg_cfg_lock #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic [DIV_W-1:0] div_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic [DIV_W-1:0] div_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [DIV_W-1:0] hi_q,
  output logic             off_q
);
  localparam logic [DIV_W:0] TWO = (DIV_W+1)'(2);

  logic [DIV_W:0] ratio_p1;
  logic [DIV_W:0] hi_calc;

  // ceil((D+1)/2) = (D+2) >> 1
  always_comb begin
    ratio_p1 = {1'b0, div_in} + TWO;
    hi_calc  = ratio_p1 >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sel_q <= '0;
      hi_q  <= '0;
      off_q <= 1'b1;
    end else if (!glb_en) begin
      div_q <= div_in;
      sel_q <= sel_in;
      hi_q  <= hi_calc[DIV_W-1:0];
      off_q <= (div_in == '0);
    end
  end
endmodule

// File: rtl/ocg_tick_sel.sv
module ocg_tick_sel #(
  parameter int NSRC  = 2,
  parameter int SEL_W = 1
) (
  input  logic [NSRC-1:0]  ce,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  generate
    if (NSRC == 1) begin : g_single
      always_comb tick = ce[0];
    end else begin : g_multi
      always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
          if (sel == SEL_W'(i)) tick = ce[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ocg_divider.sv
module ocg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             off,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  input  logic [DIV_W-1:0] hi_len,
  output logic             clk_out
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || off) begin
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (tick) begin
      clk_out <= (cnt < hi_len);
      cnt     <= (cnt == div) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdm_clkout_gen.sv
module sdm_clkout_gen #(
  parameter int DIV_W = ocg_pkg::OCG_DIV_W_DEF,
  parameter int NSRC  = ocg_pkg::OCG_NSRC_DEF,
  parameter int SEL_W = ocg_pkg::sel_width(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [NSRC-1:0]  src_ce,
  output logic             ser_clk,
  output logic [DIV_W-1:0] absence_thr
);
  logic [DIV_W-1:0] div_lk;
  logic [SEL_W-1:0] sel_lk;
  logic [DIV_W-1:0] hi_lk;
  logic             off_lk;
  logic             sel_tick;

  ocg_cfg_lock #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .glb_en (glb_en),
    .div_in (div_cfg),
    .sel_in (src_sel),
    .div_q  (div_lk),
    .sel_q  (sel_lk),
    .hi_q   (hi_lk),
    .off_q  (off_lk)
  );

  ocg_tick_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
    .ce   (src_ce),
    .sel  (sel_lk),
    .tick (sel_tick)
  );

  ocg_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (glb_en),
    .off     (off_lk),
    .tick    (sel_tick),
    .div     (div_lk),
    .hi_len  (hi_lk),
    .clk_out (ser_clk)
  );

  assign absence_thr = div_lk;
endmodule

// File: rtl/sdm_clkout_chk.sv
module sdm_clkout_chk #(
  parameter int DIV_W = 8,
  parameter int NSRC  = 2,
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic [SEL_W-1:0] src_sel,
  input logic [DIV_W-1:0] div_cfg,
  input logic [NSRC-1:0]  src_ce,
  input logic             ser_clk,
  input logic [DIV_W-1:0] absence_thr
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ser_clk && absence_thr == '0));

  a_r5_low_after_disable: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !ser_clk);

  a_r4_zero_div_idle: assert property (@(posedge clk) disable iff (rst)
    (glb_en && absence_thr == '0) |=> !ser_clk);

  a_r6_thr_locked: assert property (@(posedge clk) disable iff (rst)
    (glb_en && !$past(rst) && $past(glb_en)) |-> $stable(absence_thr));

  a_r8_thr_follows: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> (absence_thr == $past(div_cfg)));

  a_r7_no_pulse_hold: assert property (@(posedge clk) disable iff (rst)
    (glb_en && $past(glb_en) && !$past(rst) && src_ce == '0) |=> $stable(ser_clk));
endmodule

bind sdm_clkout_gen sdm_clkout_chk #(.DIV_W(DIV_W), .NSRC(NSRC), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sdm_clkout_gen_test.sv
module sdm_clkout_gen_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          glb_en = 1'b0;
  logic [0:0]    src_sel = '0;
  logic [DW-1:0] div_cfg = '0;
  logic [1:0]    src_ce = '0;
  logic          ser_clk;
  logic [DW-1:0] absence_thr;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference state
  int m_div = 0, m_src = 0, m_pos = 0, m_out = 0;

  always #2.5 clk = ~clk;

  sdm_clkout_gen uut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .src_sel(src_sel),
    .div_cfg(div_cfg), .src_ce(src_ce), .ser_clk(ser_clk),
    .absence_thr(absence_thr)
  );

  task automatic check(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // reference: position within period counted in source pulses
  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_src = 0; m_pos = 0; m_out = 0;
    end else if (!glb_en) begin
      m_div = int'(div_cfg); m_src = int'(src_sel); m_pos = 0; m_out = 0;
    end else if (m_div == 0) begin
      m_pos = 0; m_out = 0;
    end else if (src_ce[m_src]) begin
      m_out = (2 * m_pos < m_div + 1) ? 1 : 0;
      m_pos = (m_pos + 1) % (m_div + 1);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(ser_clk) == m_out, {tag, " ser_clk"}, int'(ser_clk), m_out);
      check(int'(absence_thr) == m_div, {tag, " R8 threshold"}, int'(absence_thr), m_div);
    end
  end

  // mode: 0 none, 1 every cycle on both, 2 every third on selected, 3 pseudo-random
  logic [15:0] lfsr = 16'hACE1;
  task automatic run(input int cycles, input int mode);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        1: src_ce = 2'b11;
        2: src_ce = (k % 3 == 0) ? 2'b11 : 2'b00;
        3: src_ce = lfsr[1:0];
        default: src_ce = 2'b00;
      endcase
    end
  endtask

  task automatic setup(input int d, input int s);
    @(negedge clk); #1;
    glb_en = 1'b0; src_ce = '0; div_cfg = DW'(d); src_sel = 1'(s);
    @(negedge clk); #1;
    glb_en = 1'b1;
  endtask

  initial begin
    #(5.0 * 20000);
    $display("FAIL watchdog expired actual=0 expected=1");
    n_fail++; n_chk++;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ser_clk == 1'b0, "R1 reset ser_clk", int'(ser_clk), 0);
    check(absence_thr == '0, "R1 reset threshold", int'(absence_thr), 0);
    #1 rst = 1'b0;

    // R3 R9: ratio 5, explicit waveform after enable
    tag = "R3 R9";
    setup(4, 0);
    src_ce = 2'b11;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(int'(ser_clk) == (((k % 5) < 3) ? 1 : 0), "R3 R9 wave", int'(ser_clk),
            ((k % 5) < 3) ? 1 : 0);
    end

    // R2 even and odd ratios with sparse pulses
    tag = "R2"; setup(3, 0); run(60, 2);
    tag = "R2"; setup(1, 0); run(20, 1);
    tag = "R2 R3"; setup(6, 0); run(80, 3);
    tag = "R2 max"; setup(255, 0); run(600, 1);

    // R7: audio source, independent pulse patterns
    tag = "R7"; setup(2, 1); run(150, 3);
    tag = "R7"; setup(5, 0); run(150, 3);
    // R7: only unselected source pulses, output must hold
    tag = "R7 hold"; setup(2, 1);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1; src_ce = 2'b01;
    end
    @(negedge clk);
    check(ser_clk == 1'b0, "R7 unselected ignored", int'(ser_clk), 0);

    // R4: zero divide
    tag = "R4"; setup(0, 0); run(40, 1);
    check(ser_clk == 1'b0, "R4 zero divide low", int'(ser_clk), 0);

    // R6: settings changed while running
    tag = "R6"; setup(3, 0);
    run(7, 1);
    @(negedge clk); #1; div_cfg = 8'd9; src_sel = 1'b1;
    run(30, 1);
    check(absence_thr == 8'd3, "R6 threshold locked", int'(absence_thr), 3);

    // R5: disable while output is high
    tag = "R5";
    src_ce = 2'b11;
    while (ser_clk !== 1'b1) @(negedge clk);
    #1 glb_en = 1'b0;
    @(negedge clk);
    check(ser_clk == 1'b0, "R5 low one cycle after disable", int'(ser_clk), 0);
    check(absence_thr == 8'd9, "R8 threshold follows when disabled", int'(absence_thr), 9);
    run(4, 1);

    // R6 R9: new settings take effect after re-enable
    tag = "R6 R9"; #1 glb_en = 1'b1; run(60, 3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule